// File: doc/BRIEF.md
# Systematic Reed-Solomon Block Encoder

This block encodes a stream of m-bit symbols into systematic Reed-Solomon codewords over GF(2^m). A block opens with a start pulse, which also samples the block length. The encoder then takes k_block information symbols, where k_block is the block length minus the fixed check count. It repeats each information symbol on its output three enabled clock edges after sampling it. Directly after the last information symbol, it emits the check symbols at one per enabled cycle, with no gap in the output stream.

Symbol width, field polynomial, exponent of the first generator root, root scaling and check count are all elaboration parameters. The generator polynomial is formed from them while the design elaborates. Symbols that arrive outside a block, with bypass high, or with new-data low are carried to the output at the same latency. They are tagged as non-payload and never reach the parity registers.

The control inputs have a fixed priority: clock enable, then clear, then bypass, then new-data and start. Four flags describe the stream. Two describe each output symbol: whether it is information or check, and whether it belongs to a codeword. The other two say whether the encoder will take an information symbol and whether it will take a start pulse.

Top module: `rs_block_encoder`

## Requirements
- R1: While clkEn is low, every other input is ignored and dataOut, symIsInfo, symValid, acceptData and acceptStart hold their values.
- R2: An enabled edge with syncClr high returns the encoder to idle. Three zero symbols with symIsInfo=1 and symValid=0 then leave the output, and acceptData=acceptStart=1.
- R3: A symbol sampled with passThru high leaves unchanged on dataOut with symIsInfo=1 and symValid=0, and it does not alter the check symbols. This holds during the information and the check phase, and in the check phase it delays the remaining check symbols by one slot.
- R4: While no block is open, each enabled input symbol is passed to dataOut with symIsInfo=1 and symValid=0.
- R5: A start is taken only when clkEn and newData are high and passThru is low. Its symbol is the first information symbol of a new block, and any block in progress (information or check phase) is dropped.
- R6: The output codeword is the k_block information symbols followed immediately by the NUM_CHECK check symbols. The check symbols run from the highest-degree remainder coefficient down, and input slots during the check phase are not sampled.
- R7: In the information phase, a symbol sampled with newData low is passed through with symValid=0 and no effect on parity. In the check phase, newData has no effect.
- R8: blockLen is sampled with each accepted start, and k_block = blockLen - NUM_CHECK. The legal blockLen range is NUM_CHECK+2 up to 2^SYM_W-1.
- R9: symIsInfo is 0 exactly when a check symbol is on dataOut.
- R10: symValid is 1 only for information symbols sampled in a block and for check symbols.
- R11: acceptData is 0 only during the check phase, and acceptStart is 1 only while idle. Both drop on the edge after the last information symbol and after an accepted start, respectively.
- R12: A symbol sampled at an enabled edge appears on dataOut after exactly three enabled edges.
- R13: Every completed codeword evaluates to zero at each generator root alpha^(ROOT_STEP*(GEN_START+i)), i = 0..NUM_CHECK-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clkEn | input | 1 | Clock enable; freezes all state when low |
| syncClr | input | 1 | Synchronous clear, active high |
| passThru | input | 1 | Carry the current symbol past the encoder untouched |
| newData | input | 1 | Marks dataIn as a symbol to encode |
| blockStart | input | 1 | dataIn is the first symbol of a new block |
| blockLen | input | SYM_W | Total block length, sampled at start |
| dataIn | input | SYM_W | Input symbol |
| dataOut | output | SYM_W | Output symbol |
| symIsInfo | output | 1 | Low while a check symbol is on dataOut |
| symValid | output | 1 | dataOut carries a codeword symbol |
| acceptData | output | 1 | Encoder will sample an information symbol |
| acceptStart | output | 1 | Encoder is idle and waiting for a start |

## Verification
The bench builds the encoder with 8-bit symbols, the primitive polynomial 285, first root exponent 0, unit root step and 16 check symbols. That configuration reaches the full 255-symbol code and shortened lengths down to the minimum, and its 16 parity stages keep every coefficient multiplier non-trivial. A polynomial long-division model predicts every output symbol and flag. Each finished codeword is also evaluated at all sixteen roots. Back-to-back blocks, aborts in both phases, pass-through in both phases and freeze cycles are all mixed into one stream.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INFO  = 2'd1,
    PH_CHECK = 2'd2
  } rs_phase_t;

  // Strobes from the controller to the datapath, valid for one edge.
  typedef struct packed {
    logic enable;    // clock enable
    logic clr;       // synchronous clear
    logic startBlk;  // accepted start: parity restarts from zero
    logic absorb;    // information symbol enters the parity register
    logic emit;      // top parity symbol is shifted out
  } rs_strobe_t;

endpackage

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_enc_pkg::*;
#(
  parameter int SYM_W     = 8,
  parameter int NUM_CHECK = 16
) (
  input  logic             clk,
  input  logic             clkEn,
  input  logic             syncClr,
  input  logic             passThru,
  input  logic             newData,
  input  logic             blockStart,
  input  logic [SYM_W-1:0] blockLen,
  output rs_strobe_t       strb,
  output logic             acceptData,
  output logic             acceptStart
);

  localparam int CHK_W = $clog2(NUM_CHECK);
  localparam logic [CHK_W-1:0] LAST_CHK = CHK_W'(NUM_CHECK - 1);
  localparam logic [SYM_W-1:0] CHK_CNT  = SYM_W'(NUM_CHECK);

  rs_phase_t        phase;
  logic [SYM_W-1:0] infoCnt;
  logic [SYM_W-1:0] kBlock;
  logic [CHK_W-1:0] chkCnt;
  logic             takeStart;
  logic             takeInfo;
  logic             takeCheck;
  logic             lastInfo;

  // Priority: enable, clear, bypass, then start/new-data.
  always_comb begin
    takeStart = clkEn && !syncClr && !passThru && newData && blockStart;
    takeInfo  = clkEn && !syncClr && !passThru && newData && !blockStart &&
                (phase == PH_INFO);
    takeCheck = clkEn && !syncClr && !passThru && !(newData && blockStart) &&
                (phase == PH_CHECK);
    lastInfo  = (infoCnt + 1'b1) == kBlock;

    strb.enable   = clkEn;
    strb.clr      = syncClr;
    strb.startBlk = takeStart;
    strb.absorb   = takeStart || takeInfo;
    strb.emit     = takeCheck;

    acceptData  = (phase != PH_CHECK);
    acceptStart = (phase == PH_IDLE);
  end

  always_ff @(posedge clk) begin
    if (clkEn) begin
      if (syncClr) begin
        phase   <= PH_IDLE;
        infoCnt <= '0;
        kBlock  <= '0;
        chkCnt  <= '0;
      end else if (takeStart) begin
        phase   <= PH_INFO;
        kBlock  <= blockLen - CHK_CNT;
        infoCnt <= SYM_W'(1);
        chkCnt  <= '0;
      end else if (takeInfo) begin
        if (lastInfo) begin
          phase  <= PH_CHECK;
          chkCnt <= '0;
        end
        infoCnt <= infoCnt + 1'b1;
      end else if (takeCheck) begin
        if (chkCnt == LAST_CHK) phase <= PH_IDLE;
        chkCnt <= chkCnt + 1'b1;
      end
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (syncClr)
    !clkEn |=> $stable(phase) && $stable(infoCnt) && $stable(chkCnt));

  assert_clear_idle_R2: assert property (@(posedge clk)
    (clkEn && syncClr) |=> (acceptStart && acceptData));

  assert_start_taken_R5: assert property (@(posedge clk) disable iff (syncClr)
    (clkEn && newData && blockStart && !passThru) |=> !acceptStart);

  assert_rfd_drop_R11: assert property (@(posedge clk) disable iff (syncClr)
    (takeInfo && lastInfo) |=> !acceptData);

endmodule

// File: rtl/rs_enc_datapath.sv
module rs_enc_datapath
  import rs_enc_pkg::*;
#(
  parameter int SYM_W      = 8,
  parameter int FIELD_POLY = 285,
  parameter int GEN_START  = 0,
  parameter int ROOT_STEP  = 1,
  parameter int NUM_CHECK  = 16
) (
  input  logic             clk,
  input  rs_strobe_t       strb,
  input  logic [SYM_W-1:0] dataIn,
  output logic [SYM_W-1:0] dataOut,
  output logic             symIsInfo,
  output logic             symValid
);

  localparam int PIPE_DEPTH  = 3;
  localparam int FIELD_ORDER = (1 << SYM_W) - 1;

  typedef logic [SYM_W-1:0] sym_t;

  function automatic sym_t gfMul(sym_t a, sym_t b);
    sym_t acc = '0;
    sym_t sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc ^= sh;
      sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? sym_t'(FIELD_POLY) : '0);
    end
    return acc;
  endfunction

  function automatic sym_t alphaPow(int e);
    sym_t res = sym_t'(1);
    sym_t sq  = sym_t'(2);
    for (int i = 0; i < SYM_W; i++) begin
      if (((e >> i) & 1) == 1) res = gfMul(res, sq);
      sq = gfMul(sq, sq);
    end
    return res;
  endfunction

  // Low NUM_CHECK coefficients of the monic generator polynomial.
  function automatic logic [NUM_CHECK-1:0][SYM_W-1:0] genCoeffs();
    sym_t g [NUM_CHECK+1];
    sym_t root;
    logic [NUM_CHECK-1:0][SYM_W-1:0] res;
    for (int j = 0; j <= NUM_CHECK; j++) g[j] = (j == 0) ? sym_t'(1) : '0;
    for (int i = 0; i < NUM_CHECK; i++) begin
      root = alphaPow((ROOT_STEP * (GEN_START + i)) % FIELD_ORDER);
      for (int j = NUM_CHECK; j > 0; j--) g[j] = g[j-1] ^ gfMul(g[j], root);
      g[0] = gfMul(g[0], root);
    end
    for (int j = 0; j < NUM_CHECK; j++) res[j] = g[j];
    return res;
  endfunction

  localparam logic [NUM_CHECK-1:0][SYM_W-1:0] GEN = genCoeffs();

  sym_t                  par     [NUM_CHECK];
  sym_t                  parNext [NUM_CHECK];
  sym_t                  feedback;
  sym_t                  pipeData [PIPE_DEPTH];
  logic [PIPE_DEPTH-1:0] pipeInfo;
  logic [PIPE_DEPTH-1:0] pipeRdy;

  assign feedback = dataIn ^ (strb.startBlk ? '0 : par[NUM_CHECK-1]);

  for (genvar gi = 0; gi < NUM_CHECK; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_comb begin
        if (strb.absorb)    parNext[gi] = gfMul(feedback, GEN[gi]);
        else if (strb.emit) parNext[gi] = '0;
        else                parNext[gi] = par[gi];
      end
    end else begin : g_rest
      always_comb begin
        if (strb.absorb)
          parNext[gi] = (strb.startBlk ? '0 : par[gi-1]) ^ gfMul(feedback, GEN[gi]);
        else if (strb.emit)
          parNext[gi] = par[gi-1];
        else
          parNext[gi] = par[gi];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.enable) begin
      if (strb.clr) begin
        for (int i = 0; i < NUM_CHECK; i++) par[i] <= '0;
        for (int i = 0; i < PIPE_DEPTH; i++) pipeData[i] <= '0;
        pipeInfo <= '1;
        pipeRdy  <= '0;
      end else begin
        for (int i = 0; i < NUM_CHECK; i++) par[i] <= parNext[i];
        pipeData[0] <= strb.emit ? par[NUM_CHECK-1] : dataIn;
        pipeInfo[0] <= !strb.emit;
        pipeRdy[0]  <= strb.emit || strb.absorb;
        for (int i = 1; i < PIPE_DEPTH; i++) begin
          pipeData[i] <= pipeData[i-1];
          pipeInfo[i] <= pipeInfo[i-1];
          pipeRdy[i]  <= pipeRdy[i-1];
        end
      end
    end
  end

  assign dataOut   = pipeData[PIPE_DEPTH-1];
  assign symIsInfo = pipeInfo[PIPE_DEPTH-1];
  assign symValid  = pipeRdy[PIPE_DEPTH-1];

  assert_out_frozen_R1: assert property (@(posedge clk) disable iff (strb.clr)
    !strb.enable |=> $stable(dataOut) && $stable(symIsInfo) && $stable(symValid));

  assert_parity_untouched_R3: assert property (@(posedge clk) disable iff (strb.clr)
    (strb.enable && !strb.absorb && !strb.emit) |=>
      $stable(par[0]) && $stable(par[NUM_CHECK-1]));

endmodule

// File: rtl/rs_block_encoder.sv
module rs_block_encoder
  import rs_enc_pkg::*;
#(
  parameter int SYM_W      = 8,
  parameter int FIELD_POLY = 285,
  parameter int GEN_START  = 0,
  parameter int ROOT_STEP  = 1,
  parameter int NUM_CHECK  = 16
) (
  input  logic             clk,
  input  logic             clkEn,
  input  logic             syncClr,
  input  logic             passThru,
  input  logic             newData,
  input  logic             blockStart,
  input  logic [SYM_W-1:0] blockLen,
  input  logic [SYM_W-1:0] dataIn,
  output logic [SYM_W-1:0] dataOut,
  output logic             symIsInfo,
  output logic             symValid,
  output logic             acceptData,
  output logic             acceptStart
);

  rs_strobe_t strb;

  rs_enc_ctrl #(
    .SYM_W     (SYM_W),
    .NUM_CHECK (NUM_CHECK)
  ) u_ctrl (
    .clk         (clk),
    .clkEn       (clkEn),
    .syncClr     (syncClr),
    .passThru    (passThru),
    .newData     (newData),
    .blockStart  (blockStart),
    .blockLen    (blockLen),
    .strb        (strb),
    .acceptData  (acceptData),
    .acceptStart (acceptStart)
  );

  rs_enc_datapath #(
    .SYM_W      (SYM_W),
    .FIELD_POLY (FIELD_POLY),
    .GEN_START  (GEN_START),
    .ROOT_STEP  (ROOT_STEP),
    .NUM_CHECK  (NUM_CHECK)
  ) u_datapath (
    .clk       (clk),
    .strb      (strb),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .symIsInfo (symIsInfo),
    .symValid  (symValid)
  );

endmodule

// File: tb/rs_block_encoder_bench.sv
module rs_block_encoder_bench;

  localparam int W    = 8;
  localparam int POLY = 285;
  localparam int GS   = 0;
  localparam int HS   = 1;
  localparam int R    = 16;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         clkEn = 1'b0, syncClr = 1'b0, passThru = 1'b0;
  logic         newData = 1'b0, blockStart = 1'b0;
  logic [W-1:0] blockLen = '0, dataIn = '0;
  logic [W-1:0] dataOut;
  logic         symIsInfo, symValid, acceptData, acceptStart;

  always #4 clk = ~clk;

  rs_block_encoder #(
    .SYM_W(W), .FIELD_POLY(POLY), .GEN_START(GS), .ROOT_STEP(HS), .NUM_CHECK(R)
  ) u_rs_block_encoder (
    .clk(clk), .clkEn(clkEn), .syncClr(syncClr), .passThru(passThru),
    .newData(newData), .blockStart(blockStart), .blockLen(blockLen),
    .dataIn(dataIn), .dataOut(dataOut), .symIsInfo(symIsInfo),
    .symValid(symValid), .acceptData(acceptData), .acceptStart(acceptStart)
  );

  typedef struct {
    int    data;
    bit    info;
    bit    rdy;
    string tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  int    gen[R+1];
  int    mPhase = 0;   // 0 idle, 1 information, 2 check
  int    mK, mCnt, mChk;
  int    mInfo[$];
  int    mPar[R];
  string curTag = "R6";
  int    prevData;
  bit    prevInfo, prevRdy, prevRfd, prevRffd;

  function automatic int gfm(int a, int b);
    int acc = 0;
    for (int i = 0; i < W; i++) begin
      if (((b >> i) & 1) == 1) acc ^= a;
      a = a << 1;
      if (((a >> W) & 1) == 1) a ^= POLY;
    end
    return acc & MASK;
  endfunction

  function automatic int apow(int e);
    int v = 1;
    for (int i = 0; i < e; i++) v = gfm(v, 2);
    return v;
  endfunction

  task automatic checkVal(int got, int exp, string tag, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // Reference parity by schoolbook long division, then root evaluation (R13).
  task automatic finishBlock();
    int c[$];
    int cw[$];
    int coef, acc, x;
    c = mInfo;
    for (int j = 0; j < R; j++) c.push_back(0);
    for (int i = 0; i < mK; i++) begin
      coef = c[i];
      for (int j = 1; j <= R; j++) c[i+j] ^= gfm(coef, gen[R-j]);
    end
    for (int j = 0; j < R; j++) mPar[j] = c[mK+j];
    cw = mInfo;
    for (int j = 0; j < R; j++) cw.push_back(mPar[j]);
    for (int i = 0; i < R; i++) begin
      x = apow((HS * (GS + i)) % MASK);
      acc = 0;
      foreach (cw[s]) acc = gfm(acc, x) ^ cw[s];
      checkVal(acc, 0, "R13", "codeword at root");
    end
  endtask

  // Driver: applies one cycle, pushes the expected output item; the monitor
  // part pops the item pushed three enabled edges earlier (R12).
  task automatic step(bit ce, bit clr, bit byp, bit nd, bit st, int n, int d);
    item_t it;
    item_t ex;
    clkEn = ce; syncClr = clr; passThru = byp; newData = nd;
    blockStart = st; blockLen = W'(n); dataIn = W'(d);
    if (ce) begin
      it.data = d & MASK; it.info = 1'b1; it.rdy = 1'b0; it.tag = "R4";
      if (clr) begin
        q.delete();
        it.data = 0; it.tag = "R2";
        q.push_back(it); q.push_back(it);
        mPhase = 0;
      end else if (byp) begin
        it.tag = "R3";
      end else if (nd && st) begin
        mInfo.delete(); mInfo.push_back(d & MASK);
        mK = n - R; mCnt = 1; mPhase = 1;
        it.rdy = 1'b1; it.tag = "R5";
      end else if (mPhase == 2) begin
        it.data = mPar[mChk]; it.info = 1'b0; it.rdy = 1'b1; it.tag = curTag;
        mChk++;
        if (mChk == R) mPhase = 0;
      end else if (mPhase == 1 && nd) begin
        mInfo.push_back(d & MASK); mCnt++;
        it.rdy = 1'b1; it.tag = curTag;
        if (mCnt == mK) begin
          finishBlock();
          mPhase = 2; mChk = 0;
        end
      end else if (mPhase == 1) begin
        it.tag = "R7";
      end
      q.push_back(it);
    end
    @(posedge clk);
    @(negedge clk);
    if (!ce) begin
      checkVal(dataOut, prevData, "R1", "frozen data");
      checkVal(symIsInfo, prevInfo, "R1", "frozen info");
      checkVal(symValid, prevRdy, "R1", "frozen valid");
      checkVal(acceptData, prevRfd, "R1", "frozen acceptData");
      checkVal(acceptStart, prevRffd, "R1", "frozen acceptStart");
    end else begin
      if (q.size() == 3) begin
        ex = q.pop_front();
        checkVal(dataOut, ex.data, ex.tag, "data");
        checkVal(symIsInfo, ex.info, {ex.tag, "/R9"}, "info flag");
        checkVal(symValid, ex.rdy, {ex.tag, "/R10"}, "valid flag");
      end
      checkVal(acceptData, mPhase != 2, "R11", "acceptData");
      checkVal(acceptStart, mPhase == 0, "R11", "acceptStart");
    end
    prevData = dataOut; prevInfo = symIsInfo; prevRdy = symValid;
    prevRfd = acceptData; prevRffd = acceptStart;
  endtask

  // Runs one block from its start pulse until the model returns to idle,
  // or stops early at abortAt so the caller can interrupt it.
  task automatic runBlock(int n, int gapEvery, int bypAt, int ceOffAt, int abortAt);
    int i = 1;
    step(1, 0, 0, 1, 1, n, (n * 13 + 1) & MASK);
    while (mPhase != 0) begin
      if (i == abortAt) return;
      step(i != ceOffAt, 0, i == bypAt,
           (gapEvery == 0) || ((i % gapEvery) != 0), 0, n,
           (i * 29 + n * 7 + 3) & MASK);
      i++;
    end
  endtask

  initial begin
    for (int j = 0; j <= R; j++) gen[j] = (j == 0) ? 1 : 0;
    for (int i = 0; i < R; i++) begin
      int root;
      root = apow((HS * (GS + i)) % MASK);
      for (int j = R; j > 0; j--) gen[j] = gen[j-1] ^ gfm(gen[j], root);
      gen[0] = gfm(gen[0], root);
    end

    // R2: clear from time zero
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    // R4: idle pass-through
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0, 0, 'h40 + i);
    // R5: start with newData low, or with bypass high, is ignored
    step(1, 0, 0, 0, 1, 30, 'h55);
    checkVal(acceptStart, 1, "R5", "start with newData low ignored");
    step(1, 0, 1, 1, 1, 30, 'h56);
    checkVal(acceptStart, 1, "R5", "start with bypass ignored");

    // R6: full-length (255,239) block
    curTag = "R6";
    runBlock(255, 0, 0, 0, 0);
    // R8: shortened block, newData gaps, bypass and a freeze in the info phase
    curTag = "R8";
    runBlock(40, 3, 10, 12, 0);
    // R7 / R3: back to back; bypass and newData low in the check phase
    curTag = "R7";
    runBlock(24, 4, 11, 13, 0);
    // R5: abandon in the information phase, then in the check phase
    curTag = "R5";
    runBlock(60, 0, 0, 0, 10);
    runBlock(30, 0, 0, 0, 0);
    runBlock(20, 0, 0, 0, 7);
    runBlock(22, 2, 0, 0, 0);
    // R2: clear in mid-block, then a minimum-length block (R12 latency)
    curTag = "R2";
    runBlock(50, 0, 0, 0, 5);
    step(1, 1, 0, 1, 0, 0, 'h11);
    step(0, 1, 0, 1, 1, 0, 'h12);
    step(1, 0, 0, 1, 0, 0, 'h13);
    curTag = "R12";
    runBlock(R + 2, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 'h70 + i);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule